// File: doc/BRIEF.md
# Sync-Gated Serial Receive Bit FIFO

This block collects the demodulated bit stream of a radio receiver into a small first-in first-out store that holds single bits. It does not write every bit it is given. Writing is armed by a start rule that the host chooses. The rule can wait for the valid-data flag from the demodulator, wait for a fixed sync pattern in the stream, start at once, or never start. Once filling has begun it stays on until the host turns it off. The host then drains the bits one at a time through a serial read port. An interrupt tells the host when enough bits are waiting.

All settings come from one 16-bit command word, which shares its upper byte with other commands on the same link. The low byte holds four fields:
- bits 7..4: interrupt level
- bits 3..2: start rule
- bit 1: fill enable
- bit 0: store enable

Everything runs on one clock. The recovered bit clock enters as a one-cycle strobe. Clock recovery, demodulation and the serial transport of the command are outside this block.

Top module: `rx_bit_fifo`

## Requirements
- R1: After synchronous reset the command register holds 16'hCE85. The outputs `irq`, `ovf` and `rd_bit` are 0, and with fill disabled no strobed bit is stored.
- R2: A command is taken only when `cmd_valid` is 1 and `cmd_word[15:8]` equals 8'hCE. Any other word, or a word presented without `cmd_valid`, leaves the configuration unchanged.
- R3: The store never holds more than DEPTH bits (16). A bit that arrives while the store is full is dropped and sets the sticky `ovf` output.
- R4: With start rule 2'b11 and fill enabled, filling starts one cycle after the command is taken. Every strobed bit is stored from then on.
- R5: With start rule 2'b00, filling starts in the cycle after `vdi_in` is seen high while fill is enabled. It stays on after `vdi_in` falls.
- R6: With start rule 2'b01, filling starts with the first bit after the last bit of SYNC_WORD. The bits of the pattern itself are not stored. Only bits received while fill is enabled count towards a match.
- R7: With start rule 2'b10, no bit is ever stored.
- R8: Clearing the fill enable (bit 1) stops writing at once and keeps the stored bits. Setting it again re-arms the start rule, so under rule 2'b01 a fresh sync pattern is required.
- R9: Clearing the store enable (bit 0) empties the store and clears `ovf`.
- R10: `rd_bit` shows the oldest stored bit, or 0 when the store is empty. A one-cycle `rd_pop` removes that bit, and bits leave in arrival order.
- R11: `irq` is 1 exactly when the number of stored bits is nonzero and at least the interrupt level (bits 7..4). It falls as soon as a pop takes the count below the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Command word; upper byte selects this block |
| bit_stb | input | 1 | One-cycle strobe of the recovered bit clock |
| bit_in | input | 1 | Received data bit, valid with `bit_stb` |
| vdi_in | input | 1 | Valid-data indicator from the demodulator |
| rd_pop | input | 1 | Host removes the oldest bit |
| rd_bit | output | 1 | Oldest stored bit |
| irq | output | 1 | Fill level reached |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: a store 16 bits deep and the sync pattern 16'h2DD4. A depth of 16 lets the bench sweep every interrupt level from 1 to 15. For each level it fills the store bit by bit past full, then drains it. That covers each point where `irq` rises and falls on both the write and the pop side, along with overflow and recovery from it. The 16-bit pattern is short enough that the bench can feed it whole with noise around it and then repeat it after a re-arm.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam logic [7:0]  CMD_TAG = 8'hCE;
   localparam logic [15:0] CMD_POR = 16'hCE85;

   typedef enum logic [1:0] {
      START_VDI    = 2'b00,
      START_SYNC   = 2'b01,
      START_NEVER  = 2'b10,
      START_ALWAYS = 2'b11
   } start_mode_e;

   typedef struct packed {
      logic [3:0]  level;
      start_mode_e mode;
      logic        fill_en;
      logic        fifo_en;
   } fifo_cfg_t;
endpackage

// File: rtl/rxf_cmd_decode.sv
module rxf_cmd_decode
   import rxf_pkg::*;
#(
   parameter int CMD_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd_word,
   output fifo_cfg_t        cfg
);
   localparam int CFG_W = $bits(fifo_cfg_t);

   if (CMD_W != CFG_W + 8) begin : g_bad_width
      $error("rxf_cmd_decode: CMD_W must equal config width plus 8");
   end

   logic hit;
   assign hit = cmd_valid && (cmd_word[CMD_W-1:CFG_W] == CMD_TAG);

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg <= fifo_cfg_t'(CMD_POR[CFG_W-1:0]);
      end else if (hit) begin
         cfg <= fifo_cfg_t'(cmd_word[CFG_W-1:0]);
      end
   end
endmodule

// File: rtl/rxf_sync_match.sv
module rxf_sync_match #(
   parameter int                SYNC_W    = 16,
   parameter logic [SYNC_W-1:0] SYNC_WORD = 16'h2DD4
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic bit_stb,
   input  logic bit_in,
   output logic hit
);
   localparam int SEEN_W = $clog2(SYNC_W + 1);

   if (SYNC_W < 2) begin : g_bad_sync
      $error("rxf_sync_match: SYNC_W must be at least 2");
   end

   logic [SYNC_W-1:0] sr;
   logic [SYNC_W-1:0] sr_next;
   logic [SEEN_W-1:0] seen;
   logic              primed;

   assign sr_next = {sr[SYNC_W-2:0], bit_in};
   assign primed  = seen >= SEEN_W'(SYNC_W - 1);
   assign hit     = bit_stb && !clr && primed && (sr_next == SYNC_WORD);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         sr   <= '0;
         seen <= '0;
      end else if (bit_stb) begin
         sr <= sr_next;
         if (seen != SEEN_W'(SYNC_W)) seen <= seen + 1'b1;
      end
   end
endmodule

// File: rtl/rxf_fill_ctrl.sv
module rxf_fill_ctrl
   import rxf_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  fifo_cfg_t cfg,
   input  logic      vdi_in,
   input  logic      sync_hit,
   input  logic      bit_stb,
   output logic      started,
   output logic      wr_en,
   output logic      search_clr
);
   logic go;
   logic start_cond;

   assign go = cfg.fill_en && cfg.fifo_en;

   always_comb begin
      case (cfg.mode)
         START_VDI:    start_cond = vdi_in;
         START_SYNC:   start_cond = sync_hit;
         START_ALWAYS: start_cond = 1'b1;
         default:      start_cond = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst || !go) begin
         started <= 1'b0;
      end else if (start_cond) begin
         started <= 1'b1;
      end
   end

   assign wr_en      = go && started && bit_stb;
   assign search_clr = !go || started;
endmodule

// File: rtl/rxf_bit_store.sv
module rxf_bit_store #(
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       clr,
   input  logic                       wr_en,
   input  logic                       wr_bit,
   input  logic                       rd_pop,
   output logic                       rd_bit,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       ovf
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("rxf_bit_store: DEPTH must be a power of two of at least 2");
   end

   logic             mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic             full;
   logic             push;
   logic             pop;

   assign full = count == CNT_W'(DEPTH);
   assign push = wr_en && !full;
   assign pop  = rd_pop && (count != '0);

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (rst || clr) begin
            mem[i] <= 1'b0;
         end else if (push && wr_ptr == PTR_W'(i)) begin
            mem[i] <= wr_bit;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CNT_W'(push) - CNT_W'(pop);
         if (wr_en && full) ovf <= 1'b1;
      end
   end

   assign rd_bit = (count != '0) ? mem[rd_ptr] : 1'b0;
endmodule

// File: rtl/rx_bit_fifo.sv
module rx_bit_fifo
   import rxf_pkg::*;
#(
   parameter int                DEPTH     = 16,
   parameter int                SYNC_W    = 16,
   parameter logic [SYNC_W-1:0] SYNC_WORD = 16'h2DD4
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        cmd_valid,
   input  logic [15:0] cmd_word,
   input  logic        bit_stb,
   input  logic        bit_in,
   input  logic        vdi_in,
   input  logic        rd_pop,
   output logic        rd_bit,
   output logic        irq,
   output logic        ovf
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   fifo_cfg_t        cfg;
   logic             sync_hit;
   logic             started;
   logic             wr_en;
   logic             search_clr;
   logic [CNT_W-1:0] count;

   rxf_cmd_decode #(.CMD_W(16)) u_cmd (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cfg(cfg)
   );

   rxf_sync_match #(.SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)) u_sync (
      .clk(clk), .rst(rst), .clr(search_clr), .bit_stb(bit_stb),
      .bit_in(bit_in), .hit(sync_hit)
   );

   rxf_fill_ctrl u_fill (
      .clk(clk), .rst(rst), .cfg(cfg), .vdi_in(vdi_in), .sync_hit(sync_hit),
      .bit_stb(bit_stb), .started(started), .wr_en(wr_en), .search_clr(search_clr)
   );

   rxf_bit_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst(rst), .clr(!cfg.fifo_en), .wr_en(wr_en), .wr_bit(bit_in),
      .rd_pop(rd_pop), .rd_bit(rd_bit), .count(count), .ovf(ovf)
   );

   assign irq = (count != '0) && (int'(count) >= int'(cfg.level));
endmodule

// File: rtl/rx_bit_fifo_checks.sv
module rx_bit_fifo_checks #(
   parameter int DEPTH = 16
) (
   input logic                       clk,
   input logic                       rst,
   input logic [$clog2(DEPTH+1)-1:0] count,
   input logic                       ovf,
   input logic                       fifo_en,
   input logic                       fill_en,
   input logic [1:0]                 mode,
   input logic                       started
);
   assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
      int'(count) <= DEPTH);

   assert_ovf_from_full_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(ovf) |-> int'($past(count)) == DEPTH);

   assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
      !fifo_en |=> (count == '0) && !ovf);

   assert_never_start_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(started) |-> $past(mode) != 2'b10);

   assert_fill_stop_R8: assert property (@(posedge clk) disable iff (rst)
      !fill_en |=> !started);
endmodule

bind rx_bit_fifo rx_bit_fifo_checks #(.DEPTH(DEPTH)) u_checks (
   .clk(clk), .rst(rst), .count(count), .ovf(ovf), .fifo_en(cfg.fifo_en),
   .fill_en(cfg.fill_en), .mode(cfg.mode), .started(started)
);

// File: tb/test_rx_bit_fifo.sv
module test_rx_bit_fifo;
   localparam int          CLK_PERIOD = 10;
   localparam logic [15:0] SYNC       = 16'h2DD4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cmd_valid = 1'b0;
   logic [15:0] cmd_word = '0;
   logic bit_stb = 1'b0, bit_in = 1'b0, vdi_in = 1'b0, rd_pop = 1'b0;
   logic rd_bit, irq, ovf;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_bit_fifo #(.DEPTH(16), .SYNC_W(16), .SYNC_WORD(SYNC)) i_rx_bit_fifo (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .bit_stb(bit_stb), .bit_in(bit_in), .vdi_in(vdi_in), .rd_pop(rd_pop),
      .rd_bit(rd_bit), .irq(irq), .ovf(ovf)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // low byte: {level[3:0], rule[1:0], fill, store}
   task automatic raw_cmd(input logic [15:0] w, input logic v);
      cmd_valid = v; cmd_word = w; tick();
      cmd_valid = 1'b0; tick();
   endtask

   task automatic cmd(input int lvl, input int rule, input bit fill, input bit fe);
      raw_cmd({8'hCE, 4'(lvl), 2'(rule), fill, fe}, 1'b1);
   endtask

   task automatic send(input bit b);
      bit_stb = 1'b1; bit_in = b; tick();
      bit_stb = 1'b0; tick();
   endtask

   task automatic pop(output bit b);
      b = rd_bit; rd_pop = 1'b1; tick();
      rd_pop = 1'b0;
   endtask

   task automatic send_sync();
      for (int i = 15; i >= 0; i--) send(SYNC[i]);
   endtask

   function automatic bit dbit(input int k, input int l);
      return ((k * 5 + l * 3) % 7) > 3;
   endfunction

   initial begin
      bit b;
      repeat (3) tick();
      rst = 1'b0; tick();
      // R1: reset outputs, fill disabled at power-on
      chk("R1 irq", irq, 0); chk("R1 ovf", ovf, 0); chk("R1 rd_bit", rd_bit, 0);
      repeat (4) send(1'b1);
      chk("R1 no store while fill off", rd_bit, 0);

      // R2: wrong tag and missing strobe are ignored
      raw_cmd({8'hCF, 4'd1, 2'b11, 1'b1, 1'b1}, 1'b1);
      raw_cmd({8'hCE, 4'd1, 2'b11, 1'b1, 1'b1}, 1'b0);
      send(1'b1);
      chk("R2 foreign word ignored", irq, 0);

      // R4 R11 R3 R10 R9: sweep every interrupt level
      for (int l = 1; l <= 15; l++) begin
         cmd(l, 3, 1'b0, 1'b0);
         chk("R9 ovf cleared", ovf, 0);
         cmd(l, 3, 1'b1, 1'b1);
         for (int k = 1; k <= 16; k++) begin
            send(dbit(k, l));
            chk("R11 irq on fill", irq, int'(k >= l));
            chk("R10 head bit", rd_bit, dbit(1, l));
         end
         chk("R3 no ovf at full", ovf, 0);
         send(!dbit(1, l)); send(1'b1);
         chk("R3 ovf sticky", ovf, 1);
         for (int k = 1; k <= 16; k++) begin
            pop(b);
            chk("R10 order", b, dbit(k, l));
            chk("R11 irq on drain", irq, int'((16 - k) >= l && k < 16));
         end
         chk("R10 empty reads 0", rd_bit, 0);
      end

      // R7: reserved rule never stores
      cmd(1, 0, 1'b0, 1'b0);
      cmd(1, 2, 1'b1, 1'b1);
      vdi_in = 1'b1; repeat (5) send(1'b1); vdi_in = 1'b0;
      send_sync(); send(1'b1);
      chk("R7 nothing stored", irq, 0);

      // R5: valid-data indicator rule, latched after drop
      cmd(1, 0, 1'b1, 1'b1);
      send(1'b1); send(1'b1);
      chk("R5 waits for vdi", irq, 0);
      vdi_in = 1'b1; tick(); vdi_in = 1'b0; tick();
      send(1'b1); send(1'b0); send(1'b1);
      pop(b); chk("R5 bit0", b, 1);
      pop(b); chk("R5 bit1", b, 0);
      pop(b); chk("R5 bit2", b, 1);
      chk("R5 drained", irq, 0);

      // R6: sync rule, pattern bits not stored
      cmd(1, 1, 1'b0, 1'b1);
      cmd(1, 1, 1'b1, 1'b1);
      send(1'b0); send(1'b1); send(1'b1);
      send_sync();
      chk("R6 pattern not stored", irq, 0);
      send(1'b1); send(1'b1); send(1'b0);
      pop(b); chk("R6 data0", b, 1);
      pop(b); chk("R6 data1", b, 1);
      pop(b); chk("R6 data2", b, 0);
      // R8: re-arm needs a fresh pattern
      cmd(1, 1, 1'b0, 1'b1);
      cmd(1, 1, 1'b1, 1'b1);
      repeat (4) send(1'b1);
      chk("R8 re-armed search", irq, 0);
      send_sync(); send(1'b0);
      chk("R6 fresh match", irq, 1);
      pop(b); chk("R6 data after rearm", b, 0);

      // R8: clearing fill keeps bits, stops writes
      cmd(1, 3, 1'b1, 1'b1);
      send(1'b1); send(1'b0); send(1'b1);
      cmd(1, 3, 1'b0, 1'b1);
      send(1'b0); send(1'b0);
      pop(b); chk("R8 kept0", b, 1);
      pop(b); chk("R8 kept1", b, 0);
      pop(b); chk("R8 kept2", b, 1);
      chk("R8 no write after stop", irq, 0);

      // R9: clearing store enable empties it
      cmd(1, 3, 1'b1, 1'b1);
      send(1'b1); send(1'b1);
      cmd(1, 3, 1'b1, 1'b0);
      chk("R9 irq after clear", irq, 0);
      chk("R9 rd_bit after clear", rd_bit, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule